// File: doc/BRIEF.md
# Boot-Latched Event Delivery Mode Selector

This block decides, once per boot, whether platform events leave on a legacy event output or on an exposed GPIO-interrupt output. During a boot, a software agent may issue a "mode supported" request. The request carries a revision, a function index and an argument. A request whose three fields hold the accepted values sets a pending flag for that boot. The block answers every request with a one-cycle acknowledge or error pulse.

On each boot strobe, the active mode takes the value of the pending flag, and the flag is cleared for the boot that is starting. Exposed delivery therefore begins one boot after the first request. The agent has to repeat the request in every boot to keep exposed delivery. Once the agent stops, the boot after its last request still runs in exposed mode, with nobody servicing the interrupt path. Legacy delivery returns only at the boot after that. The retained state is modelled as ordinary flops that only the cold power-up reset clears.

Top module: `evt_mode_select`

## Requirements
- R1: After cold reset (rst_n low), the outputs are as follows: mode_exposed=0, next_exposed=0, req_ack=0 and req_err=0.
- R2: An accepted request is a request whose fields are revision=ACC_REV, function=ACC_FN and argument=ACC_ARG (all 1 by default). When an accepted request arrives outside a boot strobe, req_ack and next_exposed are 1 in the cycle after it, and mode_exposed does not change.
- R3: On a boot strobe, mode_exposed takes the value that next_exposed held in the strobe cycle. next_exposed is then cleared unless a request is accepted in that same cycle.
- R4: mode_exposed changes only in the cycle after a boot strobe.
- R5: A request with any field mismatched gives req_err=1 and req_ack=0 in the next cycle. It leaves next_exposed unchanged.
- R6: With mode_exposed=0, legacy_evt equals evt_in and gpio_irq is 0, in the same cycle.
- R7: With mode_exposed=1, gpio_irq equals evt_in and legacy_evt is 0, in the same cycle.
- R8: After the last accepted request, one boot strobe still leaves mode_exposed=1. The second boot strobe returns it to 0.
- R9: A request accepted in the same cycle as a boot strobe counts for the boot that is starting: next_exposed is 1 afterwards.
- R10: Repeated accepted requests within one boot are each acknowledged and keep next_exposed at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold power-up reset, active low |
| boot_stb | input | 1 | One-cycle boot transition strobe |
| req_vld | input | 1 | Request strobe |
| req_rev | input | REV_W | Request revision |
| req_fn | input | FN_W | Request function index |
| req_arg | input | ARG_W | Request argument |
| req_ack | output | 1 | Request accepted, one cycle after req_vld |
| req_err | output | 1 | Request rejected, one cycle after req_vld |
| evt_in | input | EVT_W | Platform event lines |
| legacy_evt | output | EVT_W | Legacy event delivery |
| gpio_irq | output | EVT_W | Exposed GPIO-interrupt delivery |
| mode_exposed | output | 1 | Active mode for this boot (1 = exposed) |
| next_exposed | output | 1 | Mode selected for the next boot |

## Verification
The bench builds the block with EVT_W=4, REV_W=4, FN_W=4 and ARG_W=8, and keeps the accepted values at 1. These narrow fields allow a separate mismatch in each of the three fields, including an argument above 1. The 4-bit event bus allows distinct patterns to be checked on both delivery paths. The full sequence through several boots is run: first request, steady exposed delivery, a request that coincides with a strobe, and the two-strobe fallback.

// File: rtl/evt_mode_select.sv
module evt_mode_select #(
  parameter int EVT_W   = 16,
  parameter int REV_W   = 8,
  parameter int FN_W    = 8,
  parameter int ARG_W   = 32,
  parameter int ACC_REV = 1,
  parameter int ACC_FN  = 1,
  parameter int ACC_ARG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_stb,
  input  logic             req_vld,
  input  logic [REV_W-1:0] req_rev,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [ARG_W-1:0] req_arg,
  output logic             req_ack,
  output logic             req_err,
  input  logic [EVT_W-1:0] evt_in,
  output logic [EVT_W-1:0] legacy_evt,
  output logic [EVT_W-1:0] gpio_irq,
  output logic             mode_exposed,
  output logic             next_exposed
);

  localparam logic [REV_W-1:0] REV_OK = REV_W'(ACC_REV);
  localparam logic [FN_W-1:0]  FN_OK  = FN_W'(ACC_FN);
  localparam logic [ARG_W-1:0] ARG_OK = ARG_W'(ACC_ARG);

  logic fields_ok, accept;
  logic mode_q, seen_q;

  assign fields_ok = (req_rev == REV_OK) && (req_fn == FN_OK) && (req_arg == ARG_OK);
  assign accept    = req_vld && fields_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      seen_q  <= 1'b0;
      req_ack <= 1'b0;
      req_err <= 1'b0;
    end else begin
      req_ack <= accept;
      req_err <= req_vld && !fields_ok;
      if (boot_stb) begin
        mode_q <= seen_q;
        seen_q <= accept;
      end else if (accept) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign mode_exposed = mode_q;
  assign next_exposed = seen_q;
  assign legacy_evt   = mode_q ? '0 : evt_in;
  assign gpio_irq     = mode_q ? evt_in : '0;

  // R2: accepted request outside a strobe is acknowledged and sets the pending mode
  a_r2_accept_sets_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !boot_stb && req_rev == REV_OK && req_fn == FN_OK && req_arg == ARG_OK)
      |=> (req_ack && next_exposed && $stable(mode_exposed)));

  // R3: strobe hands the pending choice to the active mode
  a_r3_boot_loads_mode: assert property (@(posedge clk) disable iff (!rst_n)
    boot_stb |=> (mode_exposed == $past(next_exposed)));

  // R4: no mode change inside a boot
  a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_stb |=> $stable(mode_exposed));

  // R5: mismatched request flagged, pending mode untouched
  a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !boot_stb && !(req_rev == REV_OK && req_fn == FN_OK && req_arg == ARG_OK))
      |=> (req_err && !req_ack && $stable(next_exposed)));

  // R6, R7: an event line never appears on both paths
  always_comb begin
    a_r7_paths_exclusive: assert ((legacy_evt & gpio_irq) == '0);
  end

endmodule

// File: tb/evt_mode_select_tb_top.sv
module evt_mode_select_tb_top;
  localparam int EW = 4, RW = 4, FW = 4, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, boot_stb = 1'b0, req_vld = 1'b0;
  logic [RW-1:0] req_rev = '0;
  logic [FW-1:0] req_fn = '0;
  logic [AW-1:0] req_arg = '0;
  logic [EW-1:0] evt_in = '0;
  logic req_ack, req_err, mode_exposed, next_exposed;
  logic [EW-1:0] legacy_evt, gpio_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_mode_select #(.EVT_W(EW), .REV_W(RW), .FN_W(FW), .ARG_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_stb(boot_stb), .req_vld(req_vld),
    .req_rev(req_rev), .req_fn(req_fn), .req_arg(req_arg),
    .req_ack(req_ack), .req_err(req_err), .evt_in(evt_in),
    .legacy_evt(legacy_evt), .gpio_irq(gpio_irq),
    .mode_exposed(mode_exposed), .next_exposed(next_exposed));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic boot(bit with_req);
    boot_stb = 1'b1;
    if (with_req) begin req_vld = 1'b1; req_rev = 1; req_fn = 1; req_arg = 1; end
    tick();
    boot_stb = 1'b0; req_vld = 1'b0;
  endtask

  task automatic request(logic [RW-1:0] r, logic [FW-1:0] f, logic [AW-1:0] a);
    req_vld = 1'b1; req_rev = r; req_fn = f; req_arg = a;
    tick();
    req_vld = 1'b0;
  endtask

  task automatic t_reset();
    evt_in = 4'h5; #1;
    check("R1 mode", mode_exposed, 0);
    check("R1 next", next_exposed, 0);
    check("R1 ack/err", {req_ack, req_err}, 0);
    rst_n = 1'b1; tick();
    check("R6 legacy out", legacy_evt, 4'h5);
    check("R6 gpio silent", gpio_irq, 0);
  endtask

  task automatic t_reject();
    request(2, 1, 1);
    check("R5 bad rev err", {req_ack, req_err}, 2'b01);
    check("R5 bad rev next", next_exposed, 0);
    request(1, 0, 1);
    check("R5 bad fn err", {req_ack, req_err}, 2'b01);
    request(1, 1, 8'h81);
    check("R5 bad arg err", {req_ack, req_err}, 2'b01);
    check("R5 next unchanged", next_exposed, 0);
    tick();
    check("R5 err pulse ends", req_err, 0);
    boot(0);
    check("R5 rejected has no effect on mode", mode_exposed, 0);
  endtask

  task automatic t_accept_and_switch();
    request(1, 1, 1);
    check("R2 ack", {req_ack, req_err}, 2'b10);
    check("R2 next set", next_exposed, 1);
    check("R2 mode held", mode_exposed, 0);
    evt_in = 4'h9; #1;
    check("R6 still legacy", legacy_evt, 4'h9);
    boot(0);
    check("R3 mode loaded", mode_exposed, 1);
    check("R3 next cleared", next_exposed, 0);
    evt_in = 4'hA; #1;
    check("R7 gpio out", gpio_irq, 4'hA);
    check("R7 legacy silent", legacy_evt, 0);
  endtask

  task automatic t_hold_and_repeat();
    for (int i = 0; i < 5; i++) tick();
    check("R4 mode steady", mode_exposed, 1);
    request(1, 1, 1);
    check("R10 first ack", req_ack, 1);
    tick();
    request(1, 1, 1);
    check("R10 second ack", req_ack, 1);
    check("R10 next kept", next_exposed, 1);
    check("R4 mode unchanged by request", mode_exposed, 1);
  endtask

  task automatic t_same_cycle();
    boot(1);
    check("R9 mode from prior boot", mode_exposed, 1);
    check("R9 next set by strobe-cycle request", next_exposed, 1);
    check("R9 ack", req_ack, 1);
  endtask

  task automatic t_fallback();
    boot(0);
    check("R8 first strobe stays exposed", mode_exposed, 1);
    check("R8 next legacy", next_exposed, 0);
    evt_in = 4'h3; #1;
    check("R8 legacy silent in between", legacy_evt, 0);
    tick(); tick();
    boot(0);
    check("R8 second strobe legacy", mode_exposed, 0);
    check("R6 legacy restored", legacy_evt, 4'h3);
    check("R6 gpio silent", gpio_irq, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    t_reject();
    t_accept_and_switch();
    t_hold_and_repeat();
    t_same_cycle();
    t_fallback();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule